// File: doc/BRIEF.md
# Power-Management Register Bank with Shutdown Trigger

This block is the software-visible register file of a system power-management unit. It holds a sparse set of 32-bit control and status words inside a 14-bit byte-address window. A simple synchronous bus reaches it: one select strobe, a write enable, an address, write data, registered read data and a one-cycle error flag. Each implemented word comes out of reset with its own default value and otherwise keeps whatever software last wrote. The registers are plain storage and drive no power sequencing.

One word, the power-hold control at offset 0x330C, is watched. A write to it with the hold bit (bit 8) at zero raises a one-cycle shutdown request toward the system controller. A boot loader normally sets the hold bit and leaves it set. The eight information words at 0x0800 to 0x081C are general scratch storage. A secondary processor polls the one at 0x0814 as a start-up mailbox.

Top module: `pwr_ctl_regbank`

## Requirements
- R1: After reset, reads return the defaults: 0x00005300 at 0x330C, 0x00010000 at 0x0200, 0x03030000 at 0x0208, 0x00960000 at 0x0700, 0xFFF00000 at 0x341C and 0x343C, 0xFFF03FFF at 0x361C, and 0xFFFFFFFF at every word from 0x1000 to 0x13A0. bus_rdata, bus_err and shutdown_req are 0.
- R2: A write to an implemented offset replaces all 32 bits. A later read of that offset returns the written value on bus_rdata in the cycle after the read strobe.
- R3: A read of an unimplemented offset, or of an address with bits [1:0] not 00, returns 0 on bus_rdata and drives bus_err to 1 for exactly the following cycle.
- R4: A write to an unimplemented or misaligned address changes no register and drives bus_err to 1 for exactly the following cycle.
- R5: A write to 0x330C with bit 8 equal to 0 drives shutdown_req to 1 for exactly the cycle after the write, and the full written value is stored.
- R6: A write to 0x330C with bit 8 equal to 1 gives no shutdown request. A write elsewhere, including a misaligned 0x330D, gives none either, whatever its bit 8.
- R7: shutdown_req is 0 during reset and in every cycle that does not directly follow a write covered by R5. bus_err is 0 in every cycle after an idle cycle.
- R8: The eight information words at 0x0800, 0x0804 and so on up to 0x081C reset to 0 and store values independently, including the mailbox at 0x0814.
- R9: Domain words at 0x3C00 + 0x20*d, for d from 0 to 8 except 6, reset to 0x00000007 at +0x0, 0x00060007 at +0x4 and 0x00000001 at +0x8. The slot at d = 6 (0x3CC0 to 0x3CC8) is unimplemented.
- R10: 0x3D08 is the last implemented word. Addresses from 0x3D0C upward are unimplemented.
- R11: bus_rdata changes only in the cycle after a read strobe. Writes and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read, while bus_sel is high |
| bus_addr | input | 14 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | One-cycle pulse after an access to an unimplemented or misaligned address |
| shutdown_req | output | 1 | One-cycle power-off request |

## Verification
Directed accesses first read every kind of default and probe the edges of the decode: the unimplemented domain gap, the word just past the window end, the word just past the option block, and misaligned twins of mapped words. This separates a decode that is off by one word from one that is only slightly too wide. Writes to the hold word with bit 8 low and high, and writes with bit 8 low to other words and to a misaligned hold address, show whether the trigger depends on the exact offset and on that one bit. A random mix of reads and writes with a fixed seed is weighted toward the option block, the information words, the domain region and the hold word. It is compared against a reference map in the bench, so lost writes, crossed slots and spurious errors or pulses all show up as mismatches.

// File: rtl/pwr_regbank_pkg.sv
// Package: register layout of the power-management register bank.
// The map is a list of register groups, each with a base offset, a
// power-of-two stride, a word count and a common reset value. Slots are
// numbered by group in list order. Assumes groups never overlap.
package pwr_regbank_pkg;

    localparam int ADDR_W   = 14;
    localparam int DATA_W   = 32;
    localparam int NGRP     = 33;
    localparam int HOLD_BIT = 8;
    localparam logic [ADDR_W-1:0] HOLD_ADDR = 14'h330C;

    localparam int unsigned GRP_BASE [NGRP] = '{
        'h0000, 'h000C, 'h0010, 'h0200, 'h0208, 'h0400, 'h0600, 'h0700,
        'h0704, 'h0718, 'h071C, 'h0800, 'h0A00, 'h1000, 'h2000, 'h2004,
        'h2008, 'h2408, 'h2600, 'h2604, 'h3028, 'h3108, 'h330C, 'h3400,
        'h3404, 'h341C, 'h361C, 'h3C00, 'h3C04, 'h3C08, 'h3CE0, 'h3CE4,
        'h3CE8 };

    // log2 of the stride between words of a group
    localparam int unsigned GRP_SHIFT [NGRP] = '{
        2, 2, 2, 2, 2, 2, 2, 2,
        2, 2, 2, 2, 2, 2, 7, 7,
        7, 2, 5, 5, 2, 5, 2, 5,
        5, 5, 2, 5, 5, 5, 5, 5,
        5 };

    localparam int unsigned GRP_COUNT [NGRP] = '{
        1, 1, 1, 1, 1, 2, 3, 1,
        5, 1, 2, 8, 1, 233, 2, 2,
        2, 1, 2, 2, 1, 6, 1, 2,
        2, 2, 1, 6, 6, 6, 2, 2,
        2 };

    localparam logic [31:0] GRP_RESET [NGRP] = '{
        32'h0000_0000, 32'h0000_0000, 32'h0000_0001, 32'h0001_0000,
        32'h0303_0000, 32'h0000_0000, 32'h0000_0000, 32'h0096_0000,
        32'h0000_0000, 32'h0000_0001, 32'h0000_0000, 32'h0000_0000,
        32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0003, 32'h0003_0003,
        32'h0101_0001, 32'h0000_0001, 32'h0000_0003, 32'h0000_0003,
        32'h0000_0000, 32'h0000_0000, 32'h0000_5300, 32'h0000_0001,
        32'h0000_0001, 32'hFFF0_0000, 32'hFFF0_3FFF, 32'h0000_0007,
        32'h0006_0007, 32'h0000_0001, 32'h0000_0007, 32'h0006_0007,
        32'h0000_0001 };

    // First slot number owned by group g.
    function automatic int unsigned grp_first(input int g);
        int unsigned acc;
        acc = 0;
        for (int i = 0; i < NGRP; i++) begin
            if (i < g) acc += GRP_COUNT[i];
        end
        return acc;
    endfunction

    localparam int NSLOT  = grp_first(NGRP);
    localparam int SLOT_W = $clog2(NSLOT);

    // Reset value of a slot, found from the group that owns it.
    function automatic logic [31:0] slot_reset(input int s);
        logic [31:0] v;
        v = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (s >= int'(grp_first(g)) && s < int'(grp_first(g) + GRP_COUNT[g]))
                v = GRP_RESET[g];
        end
        return v;
    endfunction

endpackage

// File: rtl/pwr_addr_decode.sv
// Address decoder: maps a byte address onto a storage slot.
// One comparator per group, generated from the package tables. Assumes
// non-overlapping groups, so at most one group matches. Misaligned
// addresses never hit. Purely combinational.
module pwr_addr_decode
    import pwr_regbank_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SW = SLOT_W
) (
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [SW-1:0] slot
);

    logic [NGRP-1:0] g_hit;
    logic [SW-1:0]   g_slot [NGRP];

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int unsigned BASE  = GRP_BASE[g];
        localparam int unsigned SH    = GRP_SHIFT[g];
        localparam int unsigned CNT   = GRP_COUNT[g];
        localparam int unsigned FIRST = grp_first(g);
        logic [AW-1:0] off;
        logic [AW-1:0] word;

        // Offset from the group base and word number within the group.
        assign off  = addr - AW'(BASE);
        assign word = off >> SH;
        assign g_hit[g]  = (addr >= AW'(BASE)) && (off[SH-1:0] == '0) && (word < AW'(CNT));
        assign g_slot[g] = g_hit[g] ? (SW'(FIRST) + SW'(word)) : '0;
    end

    // Merge the group results; the groups are disjoint, so OR is enough.
    always_comb begin
        slot = '0;
        for (int g = 0; g < NGRP; g++) slot = slot | g_slot[g];
        hit = (|g_hit) && (addr[1:0] == 2'b00);
    end

endmodule

// File: rtl/pwr_reg_store.sv
// Slot storage: one 32-bit word per implemented register, each with its
// own reset value from the package. Writes replace the full word. Reads
// are registered, return 0 on a miss and leave the output alone when idle.
module pwr_reg_store
    import pwr_regbank_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = SLOT_W,
    parameter int NS = NSLOT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          hit,
    input  logic [SW-1:0] slot,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] regs [NS];

    for (genvar s = 0; s < NS; s++) begin : g_slot
        localparam logic [DW-1:0] RST = DW'(slot_reset(s));
        // Hold one register; load its default on reset, else take writes.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  regs[s] <= RST;
            else if (wr_en && hit && slot == SW'(s))     regs[s] <= wdata;
        end
    end

    // Registered read port; unmapped reads give zero.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= hit ? regs[slot] : '0;
    end

    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/pwr_hold_watch.sv
// Shutdown detector: watches writes to the power-hold word and emits a
// one-cycle request when the hold bit is written as zero. Assumes the
// caller only raises wr_en for a real bus write.
module pwr_hold_watch #(
    parameter int                AW       = 14,
    parameter int                DW       = 32,
    parameter logic [AW-1:0]     HOLD_AT  = 14'h330C,
    parameter int                HOLD_POS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          shutdown_req
);

    // Register the request so it appears for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) shutdown_req <= 1'b0;
        else        shutdown_req <= wr_en && (addr == HOLD_AT) && !wdata[HOLD_POS];
    end

    assert_quiet_after_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !shutdown_req);

endmodule

// File: rtl/pwr_ctl_regbank.sv
// Top of the power-management register bank. Splits the bus strobe into
// read and write, decodes the address, stores the words, raises the
// error pulse for unmapped or misaligned accesses and watches the hold
// word. Assumes one access per strobe cycle; read data lags by one cycle.
module pwr_ctl_regbank
    import pwr_regbank_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_err,
    output logic          shutdown_req
);

    localparam int SW = SLOT_W;

    logic          wr_en;
    logic          rd_en;
    logic          dec_hit;
    logic [SW-1:0] dec_slot;

    assign wr_en = bus_sel && bus_we;
    assign rd_en = bus_sel && !bus_we;

    pwr_addr_decode #(.AW(AW), .SW(SW)) u_dec (
        .addr (bus_addr),
        .hit  (dec_hit),
        .slot (dec_slot)
    );

    pwr_reg_store #(.DW(DW), .SW(SW), .NS(NSLOT)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .hit     (dec_hit),
        .slot    (dec_slot),
        .wdata   (bus_wdata),
        .rd_data (bus_rdata)
    );

    pwr_hold_watch #(.AW(AW), .DW(DW), .HOLD_AT(HOLD_ADDR), .HOLD_POS(HOLD_BIT)) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .addr         (bus_addr),
        .wdata        (bus_wdata),
        .shutdown_req (shutdown_req)
    );

    // Flag an access that found no register, for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_err <= 1'b0;
        else        bus_err <= bus_sel && !dec_hit;
    end

    assert_err_follows_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_sel));

    assert_miss_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && !dec_hit) |-> bus_rdata == '0);

    assert_shutdown_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(wr_en && bus_addr == HOLD_ADDR && !bus_wdata[HOLD_BIT]));

    assert_shutdown_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && bus_addr == HOLD_ADDR && !bus_wdata[HOLD_BIT] |=> shutdown_req);

endmodule

// File: tb/test_pwr_ctl_regbank.sv
module test_pwr_ctl_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [13:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        shutdown_req;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [31:0] mdl [int];
    logic [31:0] last_rd = '0;

    always #4 clk = ~clk;

    pwr_ctl_regbank i_pwr_ctl_regbank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .shutdown_req(shutdown_req)
    );

    // Reference map written from the requirements: mapped flag and default.
    function automatic bit ref_map(input int a, output logic [31:0] d);
        d = '0;
        if (a[1:0] != 2'b00 || a < 0 || a >= 'h3D0C) return 0;
        if (a >= 'h0800 && a <= 'h081C) return 1;
        if (a >= 'h1000 && a <= 'h13A0) begin d = '1; return 1; end
        if (a >= 'h3C00) begin
            if (((a - 'h3C00) >> 5) == 6) return 0;
            case (a & 'h1F)
                'h0: d = 32'h7;
                'h4: d = 32'h0006_0007;
                'h8: d = 32'h1;
                default: return 0;
            endcase
            return 1;
        end
        case (a)
            'h0000, 'h000C, 'h0400, 'h0404, 'h0600, 'h0604, 'h0608, 'h0704,
            'h0708, 'h070C, 'h0710, 'h0714, 'h071C, 'h0720, 'h0A00, 'h3028,
            'h3108, 'h3128, 'h3148, 'h3168, 'h3188, 'h31A8: return 1;
            'h0010, 'h0718, 'h2408, 'h3400, 'h3404, 'h3420, 'h3424: begin d = 32'h1; return 1; end
            'h2000, 'h2080, 'h2600, 'h2604, 'h2620, 'h2624: begin d = 32'h3; return 1; end
            'h2004, 'h2084: begin d = 32'h0003_0003; return 1; end
            'h2008, 'h2088: begin d = 32'h0101_0001; return 1; end
            'h0200: begin d = 32'h0001_0000; return 1; end
            'h0208: begin d = 32'h0303_0000; return 1; end
            'h0700: begin d = 32'h0096_0000; return 1; end
            'h330C: begin d = 32'h0000_5300; return 1; end
            'h341C, 'h343C: begin d = 32'hFFF0_0000; return 1; end
            'h361C: begin d = 32'hFFF0_3FFF; return 1; end
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One bus access, then check every output against the reference.
    task automatic acc(input bit we, input int a, input logic [31:0] d, input string tag);
        logic [31:0] dflt;
        bit          mapped;
        bit          exp_sd;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = we; bus_addr = a[13:0]; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0;
        mapped = ref_map(a, dflt);
        exp_sd = we && a == 'h330C && !d[8];
        if (!we) begin
            last_rd = mapped ? (mdl.exists(a) ? mdl[a] : dflt) : 32'h0;
            chk(tag == "" ? (mapped ? "R2" : "R3") : tag, bus_rdata, last_rd);
        end else begin
            if (mapped) mdl[a] = d;
            chk("R11", bus_rdata, last_rd);
        end
        chk(we ? "R4" : "R3", {31'b0, bus_err}, {31'b0, !mapped});
        chk(exp_sd ? "R5" : "R6", {31'b0, shutdown_req}, {31'b0, exp_sd});
        @(negedge clk);
        chk("R7", {30'b0, shutdown_req, bus_err}, 32'h0);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        // R7: quiet during reset
        repeat (3) @(negedge clk);
        chk("R7", {31'b0, shutdown_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", bus_rdata, 32'h0);
        chk("R1", {30'b0, bus_err, shutdown_req}, 32'h0);

        // R1 defaults
        acc(0, 'h330C, 0, "R1");
        acc(0, 'h0200, 0, "R1");
        acc(0, 'h0208, 0, "R1");
        acc(0, 'h0700, 0, "R1");
        acc(0, 'h341C, 0, "R1");
        acc(0, 'h343C, 0, "R1");
        acc(0, 'h361C, 0, "R1");
        acc(0, 'h1000, 0, "R1");
        acc(0, 'h13A0, 0, "R1");
        // R9 domains and gap, R10 window end
        acc(0, 'h3C00, 0, "R9");
        acc(0, 'h3CA4, 0, "R9");
        acc(0, 'h3CE8, 0, "R9");
        acc(0, 'h3CC0, 0, "R9");
        acc(0, 'h3D08, 0, "R10");
        acc(0, 'h3D0C, 0, "R10");
        acc(0, 'h3FFC, 0, "R10");
        acc(0, 'h13A4, 0, "R3");
        acc(0, 'h0202, 0, "R3");
        // R4 discarded writes
        acc(1, 'h3CC0, 32'hDEAD_BEEF, "");
        acc(0, 'h3CC0, 0, "R4");
        acc(1, 'h0209, 32'h1234_5678, "");
        acc(0, 'h0208, 0, "R4");
        // R8 information words and mailbox
        acc(0, 'h0814, 0, "R8");
        for (int i = 0; i < 8; i++) acc(1, 'h0800 + 4 * i, 32'hA500_0000 + i, "");
        for (int i = 0; i < 8; i++) acc(0, 'h0800 + 4 * i, 0, "R8");
        // R2 full word replace
        acc(1, 'h0814, 32'hFFFF_FFFF, "");
        acc(1, 'h0814, 32'h0000_0000, "");
        acc(0, 'h0814, 0, "R2");
        // R5 / R6 hold word
        acc(1, 'h330C, 32'h0000_5200, "");
        acc(0, 'h330C, 0, "R5");
        acc(1, 'h330C, 32'h0000_5300, "");
        acc(1, 'h0814, 32'h0000_0000, "");
        acc(1, 'h330D, 32'h0000_0000, "");
        acc(0, 'h330C, 0, "R6");
        acc(1, 'h330C, 32'hFFFF_FEFF, "");
        // R11 idle leaves read data
        repeat (3) @(negedge clk);
        chk("R11", bus_rdata, last_rd);

        // Random mix, weighted toward interesting regions
        for (int n = 0; n < 3000; n++) begin
            int a;
            int unsigned r;
            r = $urandom % 5;
            case (r)
                0: a = ($urandom % 'h4000) & ~3;
                1: a = 'h1000 + 4 * ($urandom % 240);
                2: a = 'h3C00 + 4 * ($urandom % 'h48);
                3: a = 'h0800 + 4 * ($urandom % 9);
                default: a = 'h330C;
            endcase
            if ($urandom % 8 == 0) a = a + 1 + ($urandom % 3);
            acc($urandom % 2 == 0, a, $urandom, "");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule